// File: doc/BRIEF.md
# Pointer-Based Register Access Controller

This block is the register-access engine that sits behind a two-wire serial host port. The block upstream of it has already removed the bit framing. It hands over one byte per valid cycle, marked with a start-of-transaction flag and a read/write direction, plus a separate end-of-transaction pulse. The controller turns this byte stream into write strobes and read requests for an external register file, and into write strobes for a 196-entry filter coefficient memory.

In a write transaction, the first byte is the address pointer. A pointer of zero opens a burst coefficient load. The burst is exactly 196 bytes long, and the pointer stays frozen during the load. Any other pointer value selects ordinary registers, and the pointer moves up by one after each access. A read transaction takes its bytes from the current pointer. The two status registers at addresses 12 and 13 are readable only as the first byte of a read transaction. Two sticky flags record a coefficient load that ended too early and bytes that arrived after the load was complete.

The controller has one state register with five states:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | No transaction is open. |
| `ST_WR_REG` | A register write run at a nonzero pointer. |
| `ST_WR_COEF` | A coefficient load is in progress. |
| `ST_COEF_FULL` | All 196 coefficients have been received. |
| `ST_RD_BURST` | A read transaction is in progress. |

It moves between them as follows:
- A start byte with the write direction goes to `ST_WR_COEF` when its value is zero, and to `ST_WR_REG` otherwise.
- A start byte with the read direction goes to `ST_RD_BURST`.
- The 196th coefficient byte moves `ST_WR_COEF` to `ST_COEF_FULL`.
- An end pulse without a start byte returns any state to `ST_IDLE`.
- A start byte wins over everything else. It leaves any state and opens the new transaction.

Top module: `rac_top`

## Requirements
- R1: A byte with `in_sot`=1 and `in_rd`=0 is stored as the new pointer. It produces no `reg_we`, `reg_re` or `coef_we`.
- R2: With a nonzero pointer in a write transaction, each data byte raises `reg_we` for one cycle. The pulse comes in the cycle after the byte, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments, and 255 is followed by 1 because zero is skipped.
- R3: With pointer zero, the data bytes raise `coef_we` with `coef_idx` running 0, 1, ... 195 and `coef_wdata` equal to the byte. The pointer does not change during the load and no `reg_we` occurs.
- R4: Write bytes after the 196th coefficient are ignored, so no strobe is produced. Each one sets the sticky flag `err_overrun`.
- R5: If an end pulse or a new start byte closes a coefficient load before its 196th byte, the sticky flag `err_short` is set. A 196th byte that arrives in the same cycle as the end pulse completes the load and does not set the flag.
- R6: A read byte at a nonzero, non-status pointer raises `reg_re` and `host_rvalid` in the next cycle. In that cycle `reg_addr` equals the pointer and `host_rdata` equals `reg_rdata`. The pointer then increments.
- R7: A read while the pointer is zero returns `host_rdata`=0x00 with `host_rvalid`=1. It raises neither `reg_re` nor `coef_we`.
- R8: The status addresses 12 and 13 are read only by the first byte of a read transaction, and the pointer does not advance after such a read. A later read byte in the same burst that finds the pointer at 12 or 13 returns 0x00 without `reg_re` and leaves the pointer unchanged.
- R9: A start byte aborts any burst that is in progress. The new pointer takes effect at once, and a new coefficient load restarts at index 0.
- R10: At most one of `reg_we`, `reg_re` and `coef_we` is high in any cycle.
- R11: After reset every strobe is low, both flags are clear, the pointer is 0 and no transaction is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_sot | input | 1 | The byte is the first of a transaction |
| in_rd | input | 1 | Direction of the byte: 1 read, 0 write |
| in_data | input | 8 | Byte value; ignored for reads |
| txn_end | input | 1 | Closes the current transaction |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_addr | output | 8 | Register address for the strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register file read data for `reg_addr`, combinational |
| host_rdata | output | 8 | Byte returned to the host |
| host_rvalid | output | 1 | `host_rdata` is valid |
| coef_we | output | 1 | Coefficient write strobe |
| coef_idx | output | 8 | Coefficient index 0..195 |
| coef_wdata | output | 8 | Coefficient data |
| err_short | output | 1 | Sticky: a coefficient load ended early |
| err_overrun | output | 1 | Sticky: bytes arrived after a full coefficient load |

## Verification
Closing a transaction and taking a byte can happen in the same cycle. The bench provokes this in two ways.
- It drives the 196th coefficient byte together with the end pulse. The load must complete and `err_short` must stay clear.
- It drives a new start byte together with the end pulse in the middle of a load. `err_short` must be set, the new pointer must take effect, and the next byte must land on coefficient index 0 or on the new register address.

Pointer sweeps across the status window, and across the wrap from 255, compare every strobe against a pointer model that the bench computes.

// File: rtl/rac_pkg.sv
package rac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_REG,
        ST_WR_COEF,
        ST_COEF_FULL,
        ST_RD_BURST
    } rac_state_e;
endpackage

// File: rtl/rac_ptr.sv
// Address pointer: load from the first write byte, step with zero skipped.
module rac_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] stepped;

    always_comb begin
        stepped = ptr + AW'(1);
        if (stepped == '0) stepped = AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= stepped;
    end
endmodule

// File: rtl/rac_coef_cnt.sv
// Coefficient byte counter for one burst load.
module rac_coef_cnt #(
    parameter int N  = 196,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [CW-1:0] idx,
    output logic          last
);
    localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

    assign last = (idx == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                idx <= '0;
        else if (clear)            idx <= '0;
        else if (step && !last)    idx <= idx + CW'(1);
    end
endmodule

// File: rtl/rac_top.sv
module rac_top
    import rac_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int COEF_N    = 196,
    parameter int STAT_LO   = 12,
    parameter int STAT_HI   = 13,
    localparam int CW       = $clog2(COEF_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sot,
    input  logic          in_rd,
    input  logic [DW-1:0] in_data,
    input  logic          txn_end,
    output logic          reg_we,
    output logic          reg_re,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid,
    output logic          coef_we,
    output logic [CW-1:0] coef_idx,
    output logic [DW-1:0] coef_wdata,
    output logic          err_short,
    output logic          err_overrun
);
    rac_state_e    state, nxt;
    logic [AW-1:0] ptr;
    logic [CW-1:0] cnt;
    logic          cnt_last;
    logic          ptr_load, ptr_inc, cnt_clr, cnt_step;
    logic          we_n, re_n, rv_n, rz_n, cwe_n, short_n, ovr_n;
    logic          rd_zero;
    logic          ptr_is_stat, ptr_is_zero, coef_open;

    assign ptr_is_stat = (ptr >= AW'(STAT_LO)) && (ptr <= AW'(STAT_HI));
    assign ptr_is_zero = (ptr == '0);
    assign coef_open   = (state == ST_WR_COEF);

    rac_ptr #(.AW(AW)) ptr_i (
        .clk(clk), .rst_n(rst_n), .load(ptr_load),
        .load_val(in_data[AW-1:0]), .inc(ptr_inc), .ptr(ptr)
    );

    rac_coef_cnt #(.N(COEF_N), .CW(CW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clr),
        .step(cnt_step), .idx(cnt), .last(cnt_last)
    );

    // Next state and the pulses that the registered outputs take next cycle.
    always_comb begin
        nxt      = state;
        ptr_load = 1'b0;
        ptr_inc  = 1'b0;
        cnt_clr  = 1'b0;
        cnt_step = 1'b0;
        we_n     = 1'b0;
        re_n     = 1'b0;
        rv_n     = 1'b0;
        rz_n     = 1'b0;
        cwe_n    = 1'b0;
        short_n  = 1'b0;
        ovr_n    = 1'b0;
        if (in_valid && in_sot) begin
            short_n = coef_open;
            if (!in_rd) begin
                ptr_load = 1'b1;
                cnt_clr  = 1'b1;
                nxt      = (in_data[AW-1:0] == '0) ? ST_WR_COEF : ST_WR_REG;
            end else begin
                nxt  = ST_RD_BURST;
                rv_n = 1'b1;
                if (ptr_is_zero) begin
                    rz_n = 1'b1;
                end else begin
                    re_n    = 1'b1;
                    ptr_inc = !ptr_is_stat;
                end
            end
        end else begin
            if (in_valid) begin
                unique case (state)
                    ST_IDLE: ;
                    ST_WR_REG: if (!in_rd) begin
                        we_n    = 1'b1;
                        ptr_inc = 1'b1;
                    end
                    ST_WR_COEF: if (!in_rd) begin
                        cwe_n    = 1'b1;
                        cnt_step = 1'b1;
                        if (cnt_last) nxt = ST_COEF_FULL;
                    end
                    ST_COEF_FULL: if (!in_rd) ovr_n = 1'b1;
                    ST_RD_BURST: if (in_rd) begin
                        rv_n = 1'b1;
                        if (ptr_is_zero || ptr_is_stat) begin
                            rz_n = 1'b1;
                        end else begin
                            re_n    = 1'b1;
                            ptr_inc = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (txn_end) begin
                nxt     = ST_IDLE;
                short_n = coef_open && !(cnt_step && cnt_last);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_we      <= 1'b0;
            reg_re      <= 1'b0;
            reg_addr    <= '0;
            reg_wdata   <= '0;
            host_rvalid <= 1'b0;
            rd_zero     <= 1'b0;
            coef_we     <= 1'b0;
            coef_idx    <= '0;
            coef_wdata  <= '0;
            err_short   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            reg_we      <= we_n;
            reg_re      <= re_n;
            host_rvalid <= rv_n;
            rd_zero     <= rz_n;
            coef_we     <= cwe_n;
            err_short   <= err_short | short_n;
            err_overrun <= err_overrun | ovr_n;
            if (we_n || re_n) reg_addr <= ptr;
            if (we_n)         reg_wdata <= in_data;
            if (cwe_n) begin
                coef_idx   <= cnt;
                coef_wdata <= in_data;
            end
        end
    end

    assign host_rdata = (host_rvalid && !rd_zero) ? reg_rdata : '0;
endmodule

// File: rtl/rac_checks.sv
module rac_checks #(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic          reg_re,
    input logic          coef_we,
    input logic [CW-1:0] coef_idx,
    input logic          host_rvalid,
    input logic [DW-1:0] host_rdata,
    input logic [DW-1:0] reg_rdata,
    input logic          err_short,
    input logic          err_overrun
);
    // R10: strobes never overlap
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, reg_re, coef_we}));

    // R5: short-load flag is sticky
    a_r5_short_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_short |=> err_short);

    // R4: overrun flag is sticky
    a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |=> err_overrun);

    // R3: back-to-back coefficient writes use consecutive indices
    a_r3_coef_step: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_we && $past(coef_we)) |-> (coef_idx == $past(coef_idx) + CW'(1)));

    // R6: every register read answers the host
    a_r6_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> (host_rvalid && host_rdata == reg_rdata));

    // R7: a read answered without the register file returns zero
    a_r7_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && !reg_re) |-> (host_rdata == '0));
endmodule

bind rac_top rac_checks #(.CW(CW), .DW(DW)) rac_checks_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .coef_we(coef_we), .coef_idx(coef_idx), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .reg_rdata(reg_rdata),
    .err_short(err_short), .err_overrun(err_overrun)
);

// File: tb/rac_top_tb_top.sv
module rac_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sot = 1'b0, in_rd = 1'b0, txn_end = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       reg_we, reg_re, host_rvalid, coef_we, err_short, err_overrun;
    logic [7:0] reg_addr, reg_wdata, reg_rdata, host_rdata, coef_idx, coef_wdata;

    int checks = 0;
    int errors = 0;

    logic       o_we, o_re, o_rv, o_cwe;
    logic [7:0] o_addr, o_wdata, o_rdata, o_cidx, o_cdata;

    always #2 clk = ~clk;

    // Register file model: read value is a function of the address
    assign reg_rdata = reg_addr ^ 8'h5A;

    rac_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sot(in_sot),
        .in_rd(in_rd), .in_data(in_data), .txn_end(txn_end),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .coef_we(coef_we), .coef_idx(coef_idx),
        .coef_wdata(coef_wdata), .err_short(err_short), .err_overrun(err_overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic capture();
        o_we = reg_we;   o_re = reg_re;       o_rv = host_rvalid; o_cwe = coef_we;
        o_addr = reg_addr; o_wdata = reg_wdata; o_rdata = host_rdata;
        o_cidx = coef_idx; o_cdata = coef_wdata;
    endtask

    task automatic xfer(input logic s, input logic r, input logic [7:0] d, input logic e);
        in_valid = 1'b1; in_sot = s; in_rd = r; in_data = d; txn_end = e;
        @(negedge clk);
        capture();
        in_valid = 1'b0; in_sot = 1'b0; in_rd = 1'b0; txn_end = 1'b0;
    endtask

    task automatic end_only();
        txn_end = 1'b1;
        @(negedge clk);
        capture();
        txn_end = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [7:0] nextp(input logic [7:0] p);
        return (p == 8'd255) ? 8'd1 : p + 8'd1;
    endfunction

    function automatic bit is_stat(input logic [7:0] p);
        return (p == 8'd12) || (p == 8'd13);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] bp, q;
        do_reset();
        // R11 reset state
        chk("R11 reg_we", reg_we, 0);
        chk("R11 reg_re", reg_re, 0);
        chk("R11 coef_we", coef_we, 0);
        chk("R11 rvalid", host_rvalid, 0);
        chk("R11 err_short", err_short, 0);
        chk("R11 err_overrun", err_overrun, 0);
        // R11 pointer 0 after reset: a read returns zero (R7)
        xfer(1, 1, 8'h00, 0);
        chk("R11/R7 rvalid", o_rv, 1);
        chk("R11/R7 rdata", o_rdata, 0);
        chk("R7 no reg_re", o_re, 0);
        chk("R7 no coef_we", o_cwe, 0);
        end_only();

        // R1, R2: write sweeps across the status window
        for (int p = 1; p <= 20; p++) begin
            xfer(1, 0, 8'(p), 0);
            chk("R1 no strobe on ptr byte", int'(o_we) + int'(o_re) + int'(o_cwe), 0);
            q = 8'(p);
            for (int k = 0; k < 3; k++) begin
                xfer(0, 0, 8'(p * 7 + k), 0);
                chk("R2 reg_we", o_we, 1);
                chk("R2 addr", o_addr, q);
                chk("R2 wdata", o_wdata, (p * 7 + k) & 255);
                q = nextp(q);
            end
            end_only();
            chk("R2 pulse ends", o_we, 0);
        end
        // R2 wrap skips zero
        xfer(1, 0, 8'd254, 0);
        q = 8'd254;
        for (int k = 0; k < 3; k++) begin
            xfer(0, 0, 8'(k), 0);
            chk("R2 wrap addr", o_addr, q);
            q = nextp(q);
        end
        end_only();

        // R6, R8: read bursts from pointers 1..16
        for (int p = 1; p <= 16; p++) begin
            xfer(1, 0, 8'(p), 0);
            end_only();
            bp = 8'(p);
            for (int k = 0; k < 4; k++) begin
                xfer(k == 0, 1, 8'h00, 0);
                chk("R6 rvalid", o_rv, 1);
                if (is_stat(bp) && k != 0) begin
                    chk("R8 refused re", o_re, 0);
                    chk("R8 refused data", o_rdata, 0);
                end else begin
                    chk("R6 re", o_re, 1);
                    chk("R6 addr", o_addr, bp);
                    chk("R6 rdata", o_rdata, bp ^ 8'h5A);
                    if (!is_stat(bp)) bp = nextp(bp);
                end
            end
            end_only();
        end

        // R3, R4: full load then extra bytes
        do_reset();
        xfer(1, 0, 8'h00, 0);
        for (int i = 0; i < 196; i++) begin
            xfer(0, 0, 8'(i * 3 + 1), 0);
            chk("R3 coef_we", o_cwe, 1);
            chk("R3 idx", o_cidx, i);
            chk("R3 data", o_cdata, (i * 3 + 1) & 255);
            chk("R3 no reg_we", o_we, 0);
        end
        xfer(0, 0, 8'hEE, 0);
        chk("R4 extra ignored", o_cwe, 0);
        chk("R4 overrun set", err_overrun, 1);
        end_only();
        chk("R5 full load no short", err_short, 0);
        // R3 pointer stayed zero: read returns 0 (R7)
        xfer(1, 1, 8'h00, 0);
        chk("R3/R7 ptr still zero", o_rdata, 0);
        chk("R7 no re", o_re, 0);
        end_only();

        // R5: 196th byte together with end
        do_reset();
        xfer(1, 0, 8'h00, 0);
        for (int i = 0; i < 196; i++) xfer(0, 0, 8'(i), i == 195);
        chk("R5 last with end idx", o_cidx, 195);
        chk("R5 last with end no short", err_short, 0);

        // R5: short load
        do_reset();
        xfer(1, 0, 8'h00, 0);
        for (int i = 0; i < 10; i++) xfer(0, 0, 8'(i), 0);
        end_only();
        chk("R5 short set", err_short, 1);
        chk("R5 no overrun", err_overrun, 0);

        // R9: start byte with end in mid-load
        do_reset();
        xfer(1, 0, 8'h00, 0);
        for (int i = 0; i < 5; i++) xfer(0, 0, 8'(i), 0);
        xfer(1, 0, 8'h00, 1);
        chk("R5/R9 abort sets short", err_short, 1);
        xfer(0, 0, 8'h77, 0);
        chk("R9 restart idx", o_cidx, 0);
        chk("R9 restart we", o_cwe, 1);
        xfer(1, 0, 8'd9, 1);
        xfer(0, 0, 8'h44, 0);
        chk("R9 new ptr we", o_we, 1);
        chk("R9 new ptr addr", o_addr, 9);
        chk("R9 no coef", o_cwe, 0);
        end_only();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule